// File: doc/BRIEF.md
# Converter Result Bus Read-Out Interface

This block sits between a 15-bit-plus-sign integrating converter core and a microprocessor. The core hands over each finished conversion as a one-cycle strobe with a 16-bit two's-complement value and an over-range flag. The block turns the value into sign and magnitude and clamps it to full scale when it is out of range. It holds the result in an output latch and presents it on an 8-bit bus. The bus is enabled only during a selected read. The host selects the block with two enables of opposite polarity: `cs` must be high and `ce_n` must be low.

A mode input picks how conversions are started. In demand mode (`cont_mode` low) each selected write strobe asks the core for one conversion, and `byte_hi` chooses which data byte a read returns. In continuous mode (`cont_mode` high) the core runs freely. The host reads three bytes in a row: low byte, high byte, then a status byte. It never touches `byte_hi` or any address line. Sign and over-range are also always visible on dedicated pins. A ready flag tells the host that a fresh result is waiting.

The sequencer has three states: `ST_IDLE` (no conversion outstanding), `ST_WAIT` (a conversion is running) and `ST_HOLD` (a result has arrived while a read is active and waits in a side register). The transitions are:
- IDLE to WAIT on a selected write in demand mode, or at once in continuous mode.
- WAIT to IDLE (demand) or WAIT to WAIT (continuous) when a result is latched.
- WAIT to HOLD when a result arrives during an active read.
- HOLD to IDLE or WAIT when the read ends and the held result is latched.

Top module: `cvr_readout`

## Requirements
- R1: `bus_oe` is high only while `cs`=1, `ce_n`=0 and `rd_n`=0. Whenever `bus_oe` is low, `bus_data` is 0.
- R2: A latched result is shown in sign-magnitude form. The low byte is magnitude bits 7..0. The high byte is {0, magnitude bits 14..8}. `neg_out` is 1 for a negative core value. For example, -300 reads as 0x2C, 0x01 with `neg_out`=1.
- R3: `ovr_out` is 1 when the core flag is set or the magnitude exceeds 32767 (core value 0x8000). In either case the magnitude reads as 0x7FFF.
- R4: In demand mode a read returns the low byte when `byte_hi`=0 and the high byte when `byte_hi`=1.
- R5: In demand mode, from ST_IDLE, a write strobe (`wr_n` low while selected) raises `conv_go` for exactly one cycle, in the cycle after the strobe is first sampled. A write strobe without selection produces no pulse.
- R6: In continuous mode `conv_go` stays high. Successive reads return low byte, high byte, then status {000000, ovr, neg}, and the fourth read wraps back to the low byte. `byte_hi` has no effect in this mode.
- R7: Latching a new result returns the continuous-mode byte sequence to the low byte.
- R8: A result that arrives while a selected read is active does not change the bus during that read. It is latched on the first clock after the read ends.
- R9: `result_ready` rises when a result is latched. In demand mode it falls after the end of any read. In continuous mode it falls only after the status byte has been read.
- R10: In demand mode a core result strobe with no conversion outstanding (ST_IDLE) is ignored, and the latch keeps its previous value.
- R11: During and right after reset, `result_ready`, `conv_go`, `ovr_out` and `neg_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; host strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; requests a conversion in demand mode |
| byte_hi | input | 1 | Demand-mode byte choice: 0 low byte, 1 high byte |
| cont_mode | input | 1 | 1 continuous conversions, 0 on-demand |
| core_valid | input | 1 | One-cycle strobe from the core: a result is ready |
| core_value | input | 16 | Two's-complement result from the core |
| core_ovr | input | 1 | Over-range flag from the core |
| conv_go | output | 1 | Conversion request to the core: a pulse in demand mode, a level in continuous mode |
| result_ready | output | 1 | A fresh, unread result is in the latch |
| ovr_out | output | 1 | Over-range of the latched result |
| neg_out | output | 1 | Polarity of the latched result, 1 for negative |
| bus_data | output | 8 | Read data, 0 while not enabled |
| bus_oe | output | 1 | Output enable for the external three-state bus driver |

## Verification
If the sequencer is stuck in the wrong state, the next conversion request or result shows it at the ports. A missing `conv_go` pulse, or a latch that does not take the new value, appears within two clocks of the strobe. A byte pointer that is wrong returns the wrong byte on the very next continuous-mode read. A ready flag that clears too early shows one clock after the first or second byte. A held result that is lost or applied too soon shows on the bus either during the read that should have frozen it or on the first read after it.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_t;

    localparam logic [1:0] PTR_LOW  = 2'd0;
    localparam logic [1:0] PTR_HIGH = 2'd1;
    localparam logic [1:0] PTR_STAT = 2'd2;

endpackage

// File: rtl/cvr_encode.sv
module cvr_encode #(
    parameter int MAG_W = 15
) (
    input  logic [MAG_W:0]   raw,
    input  logic             flag_in,
    output logic             neg,
    output logic             ovr,
    output logic [MAG_W-1:0] mag
);
    localparam int EXT_W = MAG_W + 2;
    localparam logic [EXT_W-1:0] FULL_EXT = {2'b00, {MAG_W{1'b1}}};
    localparam logic [EXT_W-1:0] ONE_EXT  = {{(EXT_W-1){1'b0}}, 1'b1};

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] absval;
    logic             too_big;

    always_comb begin
        ext     = {raw[MAG_W], raw};
        absval  = raw[MAG_W] ? (~ext + ONE_EXT) : ext;
        too_big = (absval > FULL_EXT);
        neg     = raw[MAG_W];
        ovr     = flag_in | too_big;
        mag     = ovr ? {MAG_W{1'b1}} : absval[MAG_W-1:0];
    end

endmodule

// File: rtl/cvr_strobe.sv
module cvr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic ce_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic rd_end,
    output logic wr_rise
);
    logic sel;
    logic wr_act;
    logic rd_q;
    logic wr_q;

    always_comb begin
        sel     = cs & ~ce_n;
        rd_act  = sel & ~rd_n;
        wr_act  = sel & ~wr_n;
        rd_end  = rd_q & ~rd_act;
        wr_rise = wr_act & ~wr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
        end
    end

endmodule

// File: rtl/cvr_bytesel.sv
module cvr_bytesel #(
    parameter int MAG_W = 15,
    parameter int BUS_W = 8
) (
    input  logic [MAG_W-1:0] mag,
    input  logic             neg,
    input  logic             ovr,
    input  logic             cont_mode,
    input  logic             byte_hi,
    input  logic [1:0]       ptr,
    input  logic             oe,
    output logic [BUS_W-1:0] data
);
    import cvr_pkg::*;

    localparam int HI_W = MAG_W - BUS_W;

    logic [BUS_W-1:0] lo_byte;
    logic [BUS_W-1:0] hi_byte;
    logic [BUS_W-1:0] st_byte;
    logic [1:0]       pick;
    logic [BUS_W-1:0] chosen;

    always_comb begin
        lo_byte = mag[BUS_W-1:0];
        hi_byte = {{(BUS_W-HI_W){1'b0}}, mag[MAG_W-1:BUS_W]};
        st_byte = {{(BUS_W-2){1'b0}}, ovr, neg};
        pick    = cont_mode ? ptr : {1'b0, byte_hi};
        unique case (pick)
            PTR_LOW:  chosen = lo_byte;
            PTR_HIGH: chosen = hi_byte;
            PTR_STAT: chosen = st_byte;
            default:  chosen = lo_byte;
        endcase
        data = oe ? chosen : '0;
    end

endmodule

// File: rtl/cvr_readout.sv
module cvr_readout #(
    parameter int MAG_W = 15,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             ce_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             byte_hi,
    input  logic             cont_mode,
    input  logic             core_valid,
    input  logic [MAG_W:0]   core_value,
    input  logic             core_ovr,
    output logic             conv_go,
    output logic             result_ready,
    output logic             ovr_out,
    output logic             neg_out,
    output logic [BUS_W-1:0] bus_data,
    output logic             bus_oe
);
    import cvr_pkg::*;

    seq_state_t state_q, state_nx;

    logic             rd_act, rd_end, wr_rise;
    logic             enc_neg, enc_ovr;
    logic [MAG_W-1:0] enc_mag;

    logic [MAG_W-1:0] mag_q, pend_mag;
    logic             neg_q, ovr_q, pend_neg, pend_ovr;
    logic [1:0]       ptr_q;
    logic             ready_q, go_q;

    logic latch_new, latch_pend, stash, start_pulse;

    cvr_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .ce_n    (ce_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .rd_act  (rd_act),
        .rd_end  (rd_end),
        .wr_rise (wr_rise)
    );

    cvr_encode #(.MAG_W(MAG_W)) u_encode (
        .raw     (core_value),
        .flag_in (core_ovr),
        .neg     (enc_neg),
        .ovr     (enc_ovr),
        .mag     (enc_mag)
    );

    always_comb begin
        state_nx    = state_q;
        latch_new   = 1'b0;
        latch_pend  = 1'b0;
        stash       = 1'b0;
        start_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cont_mode) begin
                    state_nx = ST_WAIT;
                end else if (wr_rise) begin
                    state_nx    = ST_WAIT;
                    start_pulse = 1'b1;
                end
            end
            ST_WAIT: begin
                if (core_valid) begin
                    if (rd_act) begin
                        stash    = 1'b1;
                        state_nx = ST_HOLD;
                    end else begin
                        latch_new = 1'b1;
                        state_nx  = cont_mode ? ST_WAIT : ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (!rd_act) begin
                    if (core_valid) latch_new = 1'b1;
                    else            latch_pend = 1'b1;
                    state_nx = cont_mode ? ST_WAIT : ST_IDLE;
                end else if (core_valid) begin
                    stash = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q    <= '0;
            neg_q    <= 1'b0;
            ovr_q    <= 1'b0;
            pend_mag <= '0;
            pend_neg <= 1'b0;
            pend_ovr <= 1'b0;
            ptr_q    <= PTR_LOW;
            ready_q  <= 1'b0;
            go_q     <= 1'b0;
        end else begin
            go_q <= cont_mode | start_pulse;
            if (stash) begin
                pend_mag <= enc_mag;
                pend_neg <= enc_neg;
                pend_ovr <= enc_ovr;
            end
            if (latch_new) begin
                mag_q   <= enc_mag;
                neg_q   <= enc_neg;
                ovr_q   <= enc_ovr;
                ptr_q   <= PTR_LOW;
                ready_q <= 1'b1;
            end else if (latch_pend) begin
                mag_q   <= pend_mag;
                neg_q   <= pend_neg;
                ovr_q   <= pend_ovr;
                ptr_q   <= PTR_LOW;
                ready_q <= 1'b1;
            end else if (rd_end) begin
                if (cont_mode) begin
                    if (ptr_q == PTR_STAT) begin
                        ptr_q   <= PTR_LOW;
                        ready_q <= 1'b0;
                    end else begin
                        ptr_q <= ptr_q + 2'd1;
                    end
                end else begin
                    ready_q <= 1'b0;
                end
            end
        end
    end

    cvr_bytesel #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_bytesel (
        .mag       (mag_q),
        .neg       (neg_q),
        .ovr       (ovr_q),
        .cont_mode (cont_mode),
        .byte_hi   (byte_hi),
        .ptr       (ptr_q),
        .oe        (rd_act),
        .data      (bus_data)
    );

    assign bus_oe       = rd_act;
    assign conv_go      = go_q;
    assign result_ready = ready_q;
    assign ovr_out      = ovr_q;
    assign neg_out      = neg_q;

endmodule

// File: rtl/cvr_readout_chk.sv
module cvr_readout_chk #(
    parameter int MAG_W = 15,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             ce_n,
    input logic             rd_n,
    input logic             cont_mode,
    input logic             conv_go,
    input logic             result_ready,
    input logic             ovr_out,
    input logic             bus_oe,
    input logic [BUS_W-1:0] bus_data,
    input logic [MAG_W-1:0] mag_q,
    input logic [1:0]       ptr_q
);
    logic rd_sel;
    assign rd_sel = cs & ~ce_n & ~rd_n;

    p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_data == '0);

    p_unselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs || ce_n) |-> !bus_oe);

    p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_out |-> mag_q == {MAG_W{1'b1}});

    p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go && $past(rst_n) && !$past(cont_mode)) |=> (!conv_go || $past(cont_mode)));

    p_go_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cont_mode) && $past(rst_n)) |-> conv_go);

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q != 2'd3);

    p_fresh_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(result_ready) && $past(rst_n)) |-> ptr_q == 2'd0);

    p_frozen_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && $past(rd_sel) && $past(rst_n)) |-> $stable(mag_q));

endmodule

bind cvr_readout cvr_readout_chk #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs           (cs),
    .ce_n         (ce_n),
    .rd_n         (rd_n),
    .cont_mode    (cont_mode),
    .conv_go      (conv_go),
    .result_ready (result_ready),
    .ovr_out      (ovr_out),
    .bus_oe       (bus_oe),
    .bus_data     (bus_data),
    .mag_q        (mag_q),
    .ptr_q        (ptr_q)
);

// File: tb/cvr_readout_tb.sv
module cvr_readout_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] val;
        logic        flg;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        neg;
        logic        ovr;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
        '{16'h0001, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0},
        '{16'hFFFF, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0},
        '{16'h7FFF, 1'b0, 8'hFF, 8'h7F, 1'b0, 1'b0},
        '{16'h8001, 1'b0, 8'hFF, 8'h7F, 1'b1, 1'b0},
        '{16'h8000, 1'b0, 8'hFF, 8'h7F, 1'b1, 1'b1},
        '{16'h1234, 1'b1, 8'hFF, 8'h7F, 1'b0, 1'b1},
        '{16'h0A5C, 1'b0, 8'h5C, 8'h0A, 1'b0, 1'b0},
        '{16'hFED4, 1'b0, 8'h2C, 8'h01, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        byte_hi = 1'b0, cont_mode = 1'b0;
    logic        core_valid = 1'b0, core_ovr = 1'b0;
    logic [15:0] core_value = '0;
    logic        conv_go, result_ready, ovr_out, neg_out, bus_oe;
    logic [7:0]  bus_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvr_readout u_dut (
        .clk (clk), .rst_n (rst_n), .cs (cs), .ce_n (ce_n), .rd_n (rd_n),
        .wr_n (wr_n), .byte_hi (byte_hi), .cont_mode (cont_mode),
        .core_valid (core_valid), .core_value (core_value), .core_ovr (core_ovr),
        .conv_go (conv_go), .result_ready (result_ready), .ovr_out (ovr_out),
        .neg_out (neg_out), .bus_data (bus_data), .bus_oe (bus_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic hi, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs = 1'b1; ce_n = 1'b0; byte_hi = hi; rd_n = 1'b0;
        #1;
        d  = bus_data;
        oe = bus_oe;
        @(negedge clk);
        rd_n = 1'b1; cs = 1'b0; ce_n = 1'b1;
    endtask

    task automatic do_request(output logic go_hi, output logic go_lo);
        @(negedge clk);
        cs = 1'b1; ce_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        #1 go_hi = conv_go;
        wr_n = 1'b1; cs = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        #1 go_lo = conv_go;
    endtask

    task automatic deliver(input logic [15:0] v, input logic f);
        @(negedge clk);
        core_valid = 1'b1; core_value = v; core_ovr = f;
        @(negedge clk);
        core_valid = 1'b0; core_ovr = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R11 watchdog: actual=timeout expected=finished");
            report();
        end
    end

    initial begin
        logic [7:0] d;
        logic oe, g1, g0;

        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "ready in reset", result_ready, 0);
        chk("R11", "go in reset", conv_go, 0);
        chk("R11", "oe in reset", bus_oe, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11", "ready after reset", result_ready, 0);
        chk("R11", "ovr after reset", ovr_out, 0);
        chk("R11", "neg after reset", neg_out, 0);

        // R1: read strobe without full selection
        @(negedge clk);
        cs = 1'b0; ce_n = 1'b0; rd_n = 1'b0; #1;
        chk("R1", "oe cs low", bus_oe, 0);
        chk("R1", "data cs low", bus_data, 0);
        cs = 1'b1; ce_n = 1'b1; #1;
        chk("R1", "oe ce_n high", bus_oe, 0);
        @(negedge clk);
        rd_n = 1'b1; cs = 1'b0; ce_n = 1'b1;

        // R5: unselected write gives no request
        @(negedge clk);
        wr_n = 1'b0;
        @(negedge clk); #1;
        chk("R5", "go unselected", conv_go, 0);
        wr_n = 1'b1;
        @(negedge clk); #1;
        chk("R5", "go unselected later", conv_go, 0);

        // R2 R3 R4 R5 R9: vector table in demand mode
        for (int i = 0; i < NVEC; i++) begin
            do_request(g1, g0);
            chk("R5", "go pulse high", g1, 1);
            chk("R5", "go pulse one cycle", g0, 0);
            deliver(VECS[i].val, VECS[i].flg);
            #1;
            chk("R9", "ready after latch", result_ready, 1);
            chk("R3", "ovr pin", ovr_out, VECS[i].ovr);
            chk("R2", "neg pin", neg_out, VECS[i].neg);
            do_read(1'b0, d, oe);
            chk("R1", "oe during read", oe, 1);
            chk("R4", "low byte", d, VECS[i].lo);
            @(negedge clk); #1;
            chk("R9", "ready cleared after read", result_ready, 0);
            do_read(1'b1, d, oe);
            chk("R4", "high byte", d, VECS[i].hi);
        end

        // R10: unsolicited result ignored in demand mode
        deliver(16'h0777, 1'b0);
        #1;
        chk("R10", "ready stays low", result_ready, 0);
        do_read(1'b0, d, oe);
        chk("R10", "latch unchanged", d, 8'h2C);

        // R8: result during an active read is held
        do_request(g1, g0);
        @(negedge clk);
        cs = 1'b1; ce_n = 1'b0; byte_hi = 1'b0; rd_n = 1'b0;
        deliver(16'h0042, 1'b0);
        #1;
        chk("R8", "bus frozen during read", bus_data, 8'h2C);
        chk("R8", "ready not yet", result_ready, 0);
        rd_n = 1'b1; cs = 1'b0; ce_n = 1'b1;
        @(negedge clk); #1;
        chk("R8", "ready after read end", result_ready, 1);
        do_read(1'b0, d, oe);
        chk("R8", "held result latched", d, 8'h42);

        // R6 R9: continuous mode three-byte reads, byte_hi ignored
        @(negedge clk);
        cont_mode = 1'b1;
        @(negedge clk); #1;
        chk("R6", "go level", conv_go, 1);
        deliver(16'hFED4, 1'b0);
        do_read(1'b1, d, oe);
        chk("R6", "cont byte 1 low", d, 8'h2C);
        do_read(1'b1, d, oe);
        chk("R6", "cont byte 2 high", d, 8'h01);
        @(negedge clk); #1;
        chk("R9", "ready kept before status", result_ready, 1);
        do_read(1'b0, d, oe);
        chk("R6", "cont byte 3 status", d, 8'h01);
        @(negedge clk); #1;
        chk("R9", "ready cleared after status", result_ready, 0);
        chk("R6", "go still high", conv_go, 1);
        do_read(1'b1, d, oe);
        chk("R6", "wrap to low", d, 8'h2C);

        // R7: new result resets the byte sequence
        deliver(16'h0005, 1'b0);
        do_read(1'b1, d, oe);
        chk("R7", "restart at low byte", d, 8'h05);

        // R3 R6: over-range status byte in continuous mode
        deliver(16'h8000, 1'b0);
        do_read(1'b0, d, oe);
        chk("R3", "clamped low", d, 8'hFF);
        do_read(1'b0, d, oe);
        chk("R3", "clamped high", d, 8'h7F);
        do_read(1'b0, d, oe);
        chk("R6", "status ovr neg", d, 8'h03);

        done = 1'b1;
        report();
    end

endmodule